// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor

This block picks the address the fetch stage reads next. Each cycle it takes the current fetch address and looks it up in a small direct-mapped target cache. On a miss, the instruction is treated as ordinary code and the next address is the sequential one. On a hit, a gshare table of 2-bit counters decides whether control flow is taken. The counter table is indexed by the fetch address XORed with a global outcome history. A taken hit uses the cached target. The exception is an entry marked as a return, which takes the top of a small return-address stack instead. That stack is pushed and popped speculatively at fetch, from the predictions themselves.

The counter index used at fetch leaves the block as metadata and travels with the instruction. When the instruction commits, the pipeline returns that index on the update port, together with:
- the instruction address,
- the resolved direction and target,
- the instruction kind,
- the original prediction.

At commit, the block trains the counter at that index and shifts the history. It writes the target cache only for taken instructions. In the same cycle it compares the resolved outcome with the prediction and raises a redirect request when they differ.

Top module: `npc_predictor`

## Requirements
- R1: After reset all target-cache entries are invalid, so every fetch predicts not taken with next PC = fetch PC + 4.
- R2: The target cache is direct-mapped. The entry is selected by PC bits [5:2], and a hit needs the entry to be valid and PC bits [31:6] to equal the stored tag. A hit on a different tag at the same entry is a miss (next PC = PC + 4).
- R3: The counter index is PC bits [9:2] XOR the 8-bit history. It is driven on `pred_pht_idx` for every fetch.
- R4: Counters reset to 01. A fetch is predicted taken only on a target-cache hit whose counter upper bit is 1. A taken non-return entry gives its cached target as the next PC.
- R5: On commit, the counter at `cm_pht_idx` is incremented if taken and decremented if not, saturating at 3 and at 0.
- R6: Every commit shifts the history left, with the resolved direction entering bit 0.
- R7: A commit writes the target cache (tag, target, kind) only when taken. A not-taken commit leaves the cache as it was. Kind encoding: 00 conditional, 01 jump, 10 call, 11 return.
- R8: A taken prediction for a kind-11 entry takes the next PC from the top of the return stack.
- R9: A taken prediction for a kind-10 entry pushes fetch PC + 4 onto the return stack. A taken prediction for a kind-11 entry pops it. Nothing changes when `fetch_valid` is low.
- R10: The return stack is an 8-entry circular buffer. A push when full overwrites the oldest entry. A pop when empty leaves the pointer where it is and yields the stale top entry.
- R11: On a commit, `mispredict` is high when the predicted direction differs from the resolved one, or when both are taken but `cm_pred_npc` differs from `cm_target`. `redirect_pc` is `cm_target` if taken, else `cm_pc` + 4.
- R12: When a commit writes the cache entry or counter that a fetch reads in the same cycle, the fetch sees the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | A fetch lookup happens this cycle |
| fetch_pc | input | 32 | Current fetch address |
| pred_npc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Fetch predicted taken |
| pred_pht_idx | output | 8 | Counter index metadata for this fetch |
| cm_valid | input | 1 | A control-flow instruction commits |
| cm_pc | input | 32 | Address of the committing instruction |
| cm_taken | input | 1 | Resolved direction |
| cm_target | input | 32 | Resolved target |
| cm_kind | input | 2 | Instruction kind (00 cond, 01 jump, 10 call, 11 return) |
| cm_pht_idx | input | 8 | Counter index carried from fetch |
| cm_pred_taken | input | 1 | Direction that was predicted at fetch |
| cm_pred_npc | input | 32 | Next PC that was predicted at fetch |
| mispredict | output | 1 | Prediction disagrees with the resolved outcome |
| redirect_pc | output | 32 | Correct next address for fetch |

## Verification
The fetch lookup and the commit update can land in the same cycle and touch the same target-cache entry. The bench provokes this by driving a fetch of an uncached address while a taken commit for that very address is on the update port. The scoreboard expects a miss in that cycle and a hit with the new target in the following one. The speculative return-stack push and pop also meet training commits across back-to-back cycles. A reference model, updated in the order lookup-then-write, judges every fetch result.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      K_COND = 2'b00,
      K_JUMP = 2'b01,
      K_CALL = 2'b10,
      K_RET  = 2'b11
   } cf_kind_e;
endpackage

// File: rtl/npc_tgt_cache.sv
module npc_tgt_cache #(
   parameter int PC_W   = 32,
   parameter int OFF_W  = 2,
   parameter int ENTRIES = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PC_W-OFF_W-1:0] lk_word,
   output logic                  lk_hit,
   output logic [PC_W-1:0]       lk_tgt,
   output logic [1:0]            lk_kind,
   input  logic                  up_valid,
   input  logic                  up_taken,
   input  logic [PC_W-OFF_W-1:0] up_word,
   input  logic [PC_W-1:0]       up_tgt,
   input  logic [1:0]            up_kind
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = PC_W - OFF_W - IDX_W;

   generate
      if (ENTRIES != (1 << IDX_W)) begin : g_bad_entries
         $error("npc_tgt_cache: ENTRIES must be a power of two");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("npc_tgt_cache: no tag bits left");
      end
   endgenerate

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [PC_W-1:0]    tgt_q  [ENTRIES];
   logic [1:0]         kind_q [ENTRIES];

   logic [IDX_W-1:0] rd_i, wr_i;
   assign rd_i = lk_word[IDX_W-1:0];
   assign wr_i = up_word[IDX_W-1:0];

   // Reads come from the registered arrays, so a same-cycle write is not seen.
   assign lk_hit  = valid_q[rd_i] && (tag_q[rd_i] == lk_word[PC_W-OFF_W-1:IDX_W]);
   assign lk_tgt  = tgt_q[rd_i];
   assign lk_kind = kind_q[rd_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i]  <= '0;
            tgt_q[i]  <= '0;
            kind_q[i] <= '0;
         end
      end else if (up_valid && up_taken) begin
         valid_q[wr_i] <= 1'b1;
         tag_q[wr_i]   <= up_word[PC_W-OFF_W-1:IDX_W];
         tgt_q[wr_i]   <= up_tgt;
         kind_q[wr_i]  <= up_kind;
      end
   end

   // R7: a not-taken commit leaves every valid bit untouched
   a_r7_nt_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken) |=> $stable(valid_q));

   // R7: a taken commit leaves its entry valid
   a_r7_taken_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken) |=> valid_q[$past(wr_i)]);
endmodule

// File: rtl/npc_gshare.sv
module npc_gshare #(
   parameter int PHT_N  = 256,
   parameter int HIST_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [$clog2(PHT_N)-1:0]  lk_bits,
   output logic [$clog2(PHT_N)-1:0]  lk_idx,
   output logic                      lk_taken,
   input  logic                      up_valid,
   input  logic                      up_taken,
   input  logic [$clog2(PHT_N)-1:0]  up_idx
);
   localparam int PIDX_W = $clog2(PHT_N);

   generate
      if (PHT_N != (1 << PIDX_W)) begin : g_bad_pht
         $error("npc_gshare: PHT_N must be a power of two");
      end
      if (HIST_W > PIDX_W) begin : g_bad_hist
         $error("npc_gshare: history wider than the counter index");
      end
   endgenerate

   logic [1:0] pht_q [PHT_N];

   generate
      if (HIST_W > 0) begin : g_hist
         logic [HIST_W-1:0] ghr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ghr_q <= '0;
            else if (up_valid) ghr_q <= {ghr_q[HIST_W-2:0], up_taken};
         end
         assign lk_idx = lk_bits ^ PIDX_W'(ghr_q);

         // R6: the newest outcome lands in the history LSB
         a_r6_hist_lsb: assert property (@(posedge clk) disable iff (!rst_n)
            up_valid |=> (ghr_q[0] == $past(up_taken)));
      end else begin : g_bimodal
         assign lk_idx = lk_bits;
      end
   endgenerate

   assign lk_taken = pht_q[lk_idx][1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PHT_N; i++) pht_q[i] <= 2'b01;
      end else if (up_valid) begin
         if (up_taken && pht_q[up_idx] != 2'b11)
            pht_q[up_idx] <= pht_q[up_idx] + 2'b01;
         else if (!up_taken && pht_q[up_idx] != 2'b00)
            pht_q[up_idx] <= pht_q[up_idx] - 2'b01;
      end
   end

   // R5: counters saturate at both ends
   a_r5_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken && pht_q[up_idx] == 2'b11) |=> (pht_q[$past(up_idx)] == 2'b11));
   a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken && pht_q[up_idx] == 2'b00) |=> (pht_q[$past(up_idx)] == 2'b00));
   // R5: a taken commit moves weakly not-taken to weakly taken
   a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken && pht_q[up_idx] == 2'b01) |=> (pht_q[$past(up_idx)] == 2'b10));
endmodule

// File: rtl/npc_ret_stack.sv
module npc_ret_stack #(
   parameter int PC_W  = 32,
   parameter int DEPTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic            pop,
   input  logic [PC_W-1:0] push_val,
   output logic [PC_W-1:0] top
);
   localparam int PTR_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || DEPTH != (1 << PTR_W)) begin : g_bad_depth
         $error("npc_ret_stack: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [PC_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] tp_q;
   logic [PTR_W:0]   cnt_q;

   assign top = mem_q[tp_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tp_q  <= '0;
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (push) begin
         // Circular: when full the slot after top is the oldest and gets overwritten.
         tp_q              <= tp_q + 1'b1;
         mem_q[tp_q + 1'b1] <= push_val;
         if (cnt_q != (PTR_W+1)'(DEPTH)) cnt_q <= cnt_q + 1'b1;
      end else if (pop && cnt_q != '0) begin
         tp_q  <= tp_q - 1'b1;
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R9: a push makes the pushed address the new top
   a_r9_push_top: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (top == $past(push_val)));
   // R10: popping an empty stack keeps the pointer
   a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && cnt_q == '0) |=> $stable(tp_q));
   // R10: occupancy never exceeds the depth
   a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/npc_predictor.sv
module npc_predictor #(
   parameter int PC_W    = 32,
   parameter int INST_B  = 4,
   parameter int BTB_N   = 16,
   parameter int PHT_N   = 256,
   parameter int HIST_W  = 8,
   parameter int RAS_N   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fetch_valid,
   input  logic [PC_W-1:0]          fetch_pc,
   output logic [PC_W-1:0]          pred_npc,
   output logic                     pred_taken,
   output logic [$clog2(PHT_N)-1:0] pred_pht_idx,
   input  logic                     cm_valid,
   input  logic [PC_W-1:0]          cm_pc,
   input  logic                     cm_taken,
   input  logic [PC_W-1:0]          cm_target,
   input  logic [1:0]               cm_kind,
   input  logic [$clog2(PHT_N)-1:0] cm_pht_idx,
   input  logic                     cm_pred_taken,
   input  logic [PC_W-1:0]          cm_pred_npc,
   output logic                     mispredict,
   output logic [PC_W-1:0]          redirect_pc
);
   import npc_pkg::*;

   localparam int OFF_W  = $clog2(INST_B);
   localparam int PIDX_W = $clog2(PHT_N);
   localparam logic [PC_W-1:0] STEP = PC_W'(INST_B);

   generate
      if (INST_B != (1 << OFF_W)) begin : g_bad_inst
         $error("npc_predictor: INST_B must be a power of two");
      end
      if (PC_W < OFF_W + PIDX_W + 1) begin : g_bad_pc
         $error("npc_predictor: PC_W too narrow for the counter index");
      end
   endgenerate

   logic            hit;
   logic [PC_W-1:0] hit_tgt;
   logic [1:0]      hit_kind;
   logic            dir_taken;
   logic [PC_W-1:0] ras_top;
   logic [PC_W-1:0] seq_pc;
   logic            is_ret, is_call;

   npc_tgt_cache #(.PC_W(PC_W), .OFF_W(OFF_W), .ENTRIES(BTB_N)) u_cache (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_word  (fetch_pc[PC_W-1:OFF_W]),
      .lk_hit   (hit),
      .lk_tgt   (hit_tgt),
      .lk_kind  (hit_kind),
      .up_valid (cm_valid),
      .up_taken (cm_taken),
      .up_word  (cm_pc[PC_W-1:OFF_W]),
      .up_tgt   (cm_target),
      .up_kind  (cm_kind)
   );

   npc_gshare #(.PHT_N(PHT_N), .HIST_W(HIST_W)) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_bits  (fetch_pc[OFF_W +: PIDX_W]),
      .lk_idx   (pred_pht_idx),
      .lk_taken (dir_taken),
      .up_valid (cm_valid),
      .up_taken (cm_taken),
      .up_idx   (cm_pht_idx)
   );

   // Direction only matters on a cache hit; a miss is always sequential.
   assign pred_taken = fetch_valid && hit && dir_taken;
   assign is_ret     = (hit_kind == K_RET);
   assign is_call    = (hit_kind == K_CALL);
   assign seq_pc     = fetch_pc + STEP;

   npc_ret_stack #(.PC_W(PC_W), .DEPTH(RAS_N)) u_ras (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (pred_taken && is_call),
      .pop      (pred_taken && is_ret),
      .push_val (seq_pc),
      .top      (ras_top)
   );

   always_comb begin
      if (!pred_taken) pred_npc = seq_pc;
      else if (is_ret) pred_npc = ras_top;
      else             pred_npc = hit_tgt;
   end

   // Resolution comparator
   assign redirect_pc = cm_taken ? cm_target : (cm_pc + STEP);
   assign mispredict  = cm_valid &&
                        ((cm_pred_taken != cm_taken) ||
                         (cm_taken && (cm_pred_npc != cm_target)));

   // R8: a taken return follows the stack top
   a_r8_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_taken && hit_kind == K_RET) |-> (pred_npc == ras_top));
   // R1: with no hit the next address is sequential
   a_r1_miss_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !hit) |-> (!pred_taken && pred_npc == fetch_pc + STEP));
   // R11: no commit, no redirect request
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cm_valid |-> !mispredict);
endmodule

// File: tb/sim_npc_predictor.sv
`timescale 1ns/1ps
module sim_npc_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic [31:0] pred_npc;
   logic        pred_taken;
   logic [7:0]  pred_pht_idx;
   logic        cm_valid = 1'b0;
   logic [31:0] cm_pc = '0;
   logic        cm_taken = 1'b0;
   logic [31:0] cm_target = '0;
   logic [1:0]  cm_kind = '0;
   logic [7:0]  cm_pht_idx = '0;
   logic        cm_pred_taken = 1'b0;
   logic [31:0] cm_pred_npc = '0;
   logic        mispredict;
   logic [31:0] redirect_pc;

   always #10 clk = ~clk;

   npc_predictor u0 (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .pred_npc(pred_npc), .pred_taken(pred_taken), .pred_pht_idx(pred_pht_idx),
      .cm_valid(cm_valid), .cm_pc(cm_pc), .cm_taken(cm_taken), .cm_target(cm_target),
      .cm_kind(cm_kind), .cm_pht_idx(cm_pht_idx), .cm_pred_taken(cm_pred_taken),
      .cm_pred_npc(cm_pred_npc), .mispredict(mispredict), .redirect_pc(redirect_pc)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // Reference model state
   bit [7:0]  ghr_m = '0;
   bit [1:0]  pht_m [256];
   bit        bv_m  [16];
   bit [25:0] btag_m[16];
   bit [31:0] btgt_m[16];
   bit [1:0]  bk_m  [16];
   bit [31:0] ras_m [8];
   bit [2:0]  rtp_m = '0;
   int        rcnt_m = 0;

   // Scoreboard queues
   logic [31:0] qf_npc[$];
   bit          qf_tk[$];
   logic [7:0]  qf_idx[$];
   string       qf_tag[$];
   bit          qc_mis[$];
   logic [31:0] qc_red[$];
   string       qc_tag[$];

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit [7:0] nxt_idx(bit [31:0] pc);
      return pc[9:2] ^ {ghr_m[6:0], 1'b1};
   endfunction

   // Driver: fetch lookup, expectation from the model state before any same-cycle commit.
   task automatic set_fetch(bit [31:0] pc, string tag);
      bit [7:0] idx;
      bit [3:0] bi;
      bit hit, tk;
      bit [31:0] npc;
      idx = pc[9:2] ^ ghr_m;
      bi  = pc[5:2];
      hit = bv_m[bi] && (btag_m[bi] == pc[31:6]);
      tk  = hit && pht_m[idx][1];
      npc = pc + 32'd4;
      if (tk) npc = (bk_m[bi] == 2'b11) ? ras_m[rtp_m] : btgt_m[bi];
      if (tk && bk_m[bi] == 2'b10) begin
         rtp_m = rtp_m + 3'd1;
         ras_m[rtp_m] = pc + 32'd4;
         if (rcnt_m < 8) rcnt_m++;
      end else if (tk && bk_m[bi] == 2'b11 && rcnt_m > 0) begin
         rtp_m = rtp_m - 3'd1;
         rcnt_m--;
      end
      qf_npc.push_back(npc);
      qf_tk.push_back(tk);
      qf_idx.push_back(idx);
      qf_tag.push_back(tag);
      fetch_valid = 1'b1;
      fetch_pc = pc;
   endtask

   task automatic set_commit(bit [31:0] pc, bit tk, bit [31:0] tgt, bit [1:0] kind,
                             bit [7:0] idx, bit ptk, bit [31:0] pnpc, string tag);
      qc_mis.push_back((ptk != tk) || (tk && pnpc != tgt));
      qc_red.push_back(tk ? tgt : pc + 32'd4);
      qc_tag.push_back(tag);
      if (tk && pht_m[idx] != 2'b11) pht_m[idx] = pht_m[idx] + 2'd1;
      else if (!tk && pht_m[idx] != 2'b00) pht_m[idx] = pht_m[idx] - 2'd1;
      ghr_m = {ghr_m[6:0], tk};
      if (tk) begin
         bv_m[pc[5:2]] = 1'b1;
         btag_m[pc[5:2]] = pc[31:6];
         btgt_m[pc[5:2]] = tgt;
         bk_m[pc[5:2]] = kind;
      end
      cm_valid = 1'b1; cm_pc = pc; cm_taken = tk; cm_target = tgt; cm_kind = kind;
      cm_pht_idx = idx; cm_pred_taken = ptk; cm_pred_npc = pnpc;
   endtask

   task automatic step();
      @(posedge clk); #1;
      fetch_valid = 1'b0;
      cm_valid = 1'b0;
   endtask

   // Monitor: compare the design's outputs mid-cycle against the queued expectations.
   always @(negedge clk) begin
      if (rst_n && fetch_valid && qf_npc.size() > 0) begin
         logic [31:0] en; bit et; logic [7:0] ei; string t;
         en = qf_npc.pop_front(); et = qf_tk.pop_front();
         ei = qf_idx.pop_front(); t = qf_tag.pop_front();
         chk(pred_npc == en, t, "pred_npc", pred_npc, en);
         chk(pred_taken == et, t, "pred_taken", 32'(pred_taken), 32'(et));
         chk(pred_pht_idx == ei, "R3", "pred_pht_idx", 32'(pred_pht_idx), 32'(ei));
      end
      if (rst_n && cm_valid && qc_mis.size() > 0) begin
         bit em; logic [31:0] er; string t;
         em = qc_mis.pop_front(); er = qc_red.pop_front(); t = qc_tag.pop_front();
         chk(mispredict == em, t, "mispredict", 32'(mispredict), 32'(em));
         chk(redirect_pc == er, "R11", "redirect_pc", redirect_pc, er);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit [7:0] gf;
      bit [31:0] p;
      for (int i = 0; i < 256; i++) pht_m[i] = 2'b01;
      for (int i = 0; i < 16; i++) begin bv_m[i] = 0; btag_m[i] = 0; btgt_m[i] = 0; bk_m[i] = 0; end
      for (int i = 0; i < 8; i++) ras_m[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1: reset state, idle outputs
      chk(!mispredict, "R1", "mispredict after reset", 32'(mispredict), 0);
      set_fetch(32'h100, "R1"); step();

      // R11: direction mispredict, R7 allocation
      set_commit(32'h100, 1, 32'h200, 2'b00, nxt_idx(32'h100), 0, 32'h104, "R11"); step();
      set_fetch(32'h100, "R4"); step();
      // R2: same entry, other tag
      set_fetch(32'h500, "R2"); step();
      // R7: not-taken commit must not allocate
      set_commit(32'h300, 0, 32'h0, 2'b00, 8'h11, 1, 32'h380, "R7"); step();
      set_fetch(32'h300, "R7"); step();
      // R11: target mismatch with matching direction
      set_commit(32'h100, 1, 32'h240, 2'b01, nxt_idx(32'h100), 1, 32'h200, "R11"); step();
      set_fetch(32'h100, "R11"); step();

      // R5: low saturation then one step up leaves 01 (not taken)
      gf = {ghr_m[3:0], 4'b0001};
      p = {22'b0, 8'h5A ^ gf, 2'b00};
      for (int k = 0; k < 3; k++) begin
         set_commit(32'h300, 0, 32'h0, 2'b00, 8'h5A, 0, 32'h304, "R5"); step();
      end
      set_commit(p, 1, 32'hF00, 2'b00, 8'h5A, 1, 32'hF00, "R5"); step();
      set_fetch(p, "R5"); step();
      // R5: high saturation then two steps down gives 01 (not taken)
      gf = {ghr_m[2:0], 5'b11100};
      p = {22'b0, 8'hC3 ^ gf, 2'b00};
      for (int k = 0; k < 3; k++) begin
         set_commit(p, 1, 32'hE00, 2'b00, 8'hC3, 1, 32'hE00, "R5"); step();
      end
      for (int k = 0; k < 2; k++) begin
         set_commit(p, 0, 32'h0, 2'b00, 8'hC3, 0, p + 32'd4, "R6"); step();
      end
      set_fetch(p, "R5"); step();

      // R9 / R8: call pushes, return pops
      set_commit(32'h040, 1, 32'h800, 2'b10, nxt_idx(32'h040), 1, 32'h800, "R9"); step();
      set_fetch(32'h040, "R9"); step();
      set_commit(32'h83C, 1, 32'h999, 2'b11, nxt_idx(32'h83C), 1, 32'h999, "R8"); step();
      set_fetch(32'h83C, "R8"); step();
      // R10: pop on empty stack
      set_fetch(32'h83C, "R10"); step();

      // R10: overflow with nine distinct calls, then drain past empty
      for (int k = 0; k < 9; k++) begin
         p = 32'h040 + 32'(4 * k);
         set_commit(p, 1, 32'h800, 2'b10, p[9:2] ^ 8'hFF, 1, 32'h800, "R6"); step();
      end
      set_commit(32'h83C, 1, 32'h999, 2'b11, 8'h0F ^ 8'hFF, 1, 32'h999, "R6"); step();
      for (int k = 0; k < 9; k++) begin
         set_fetch(32'h040 + 32'(4 * k), "R9"); step();
      end
      for (int k = 0; k < 10; k++) begin
         set_fetch(32'h83C, "R10"); step();
      end
      // R9: no stack change when fetch_valid is low; next return still predicted from model
      step();

      // R12: commit and lookup of the same entry in one cycle
      set_fetch(32'h1000, "R12");
      set_commit(32'h1000, 1, 32'h1234, 2'b01, 8'h00 ^ ghr_m, 0, 32'h1004, "R12"); step();
      set_fetch(32'h1000, "R12"); step();
      step();

      chk(qf_npc.size() == 0 && qc_mis.size() == 0, "R4", "scoreboard drained",
          32'(qf_npc.size()), 0);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule